// File: doc/BRIEF.md
# Translation Unit Control and Interrupt Register Bank

This block is the software-visible control plane of an address-translation unit. A 32-bit word-addressed register port reads and writes a small set of registers. Among them are a fixed revision word, a system-configuration word with an idle-mode selector, an auto-idle flag and a self-clearing soft-reset trigger, a status word that shows when a reset has finished, and the control bits that switch the translation datapath, the table walker and the emulator lookup on and off. A base address for the translation table is also held here.

Five fault events arrive from the translation datapath as single-cycle pulses, together with the virtual address involved. Each event sets a sticky status bit. A single interrupt line goes high while any status bit has its enable bit set. An event that is enabled also loads its address into the fault-address register. Software clears status bits by writing ones to them, normally by writing back the value it just read.

The read data is a combinational function of the address and the register state. A write takes effect at the clock edge where `reg_wr` is high.

Top module: `mmu_ctl_regs`

## Requirements
- R1: Word offset 0 always reads 0x00000011: major version 1 in bits 7:4 and minor version 1 in bits 3:0. Writes to it have no effect.
- R2: After the synchronous reset, the status word at offset 2 reads 1 and `irq` is low. Offsets 1, 3, 4, 5, 6 and 7 all read 0.
- R3: Writing offset 1 with bit 1 set starts a soft reset that lasts exactly 16 cycles. That edge clears every writable register, the status bits and the fault address. During the 16 cycles, offset 1 bit 1 reads 1 and offset 2 bit 0 reads 0, and register writes and fault events are ignored. Afterwards offset 1 bit 1 reads 0 and offset 2 bit 0 reads 1.
- R4: Offset 1 bits 4:3 hold the idle mode, with 0 = force-idle, 1 = no-idle and 2 = smart-idle. A write carrying code 3 leaves the field unchanged. Bit 0 is auto-idle. The field drives `idle_mode` and bit 0 drives `auto_idle`.
- R5: The status word at offset 3 uses this layout: bit 0 TLB miss, bit 1 translation fault, bit 2 emulation miss, bit 3 table-walk fault, bit 4 multi-hit fault. `evt_in` uses the same layout. An event sets its bit whatever the enable setting, and the bit stays set until it is cleared.
- R6: Writing offset 3 clears each status bit whose write-data bit is 1. Bits written with 0 are kept.
- R7: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R8: Offset 4 holds the interrupt enables in the layout of R5. `irq` is high exactly when some status bit and its enable bit are both 1, and it changes in the cycle after the status or enable write.
- R9: Offset 5 bits 3:1 hold datapath enable (bit 1), table-walk enable (bit 2) and emulator-lookup enable (bit 3). They drive `ctl_en[0]`, `ctl_en[1]` and `ctl_en[2]`. The other bits read 0.
- R10: Offset 7 stores the translation-table base with bits 13:0 forced to zero, and drives `table_base`.
- R11: Offset 6 (read-only) loads `evt_addr` when an event arrives whose enable bit is set. An event that is not enabled leaves it unchanged.
- R12: Word offsets 8 to 15 read 0. Writes to them, and to offsets 0, 2 and 6, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_in | input | 5 | Fault event pulses, layout as R5 |
| evt_addr | input | 32 | Virtual address that goes with `evt_in` |
| irq | output | 1 | Interrupt request |
| ctl_en | output | 3 | Datapath, walker and emulator-lookup enables |
| idle_mode | output | 2 | Idle-mode code |
| auto_idle | output | 1 | Auto-idle enable |
| table_base | output | 32 | Translation-table base address |

## Verification
The assertions assume that `evt_in` and the register strobe are sampled once per clock and carry no X after reset. They also assume that the only source of change for the sticky status is an event or a write, and that `evt_addr` is valid in the same cycle as its event. The bench drives all inputs at falling edges, keeps `reg_wr` to one-cycle pulses, and holds `evt_in` at zero except during deliberate single-cycle pulses. It overlaps events with writes only in the same-bit race of R7 and during the soft-reset window.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int NUM_EVT   = 5;
    localparam int TTB_ALIGN = 14;
    localparam int SRST_LEN  = 16;

    localparam logic [7:0] REV_WORD = 8'h11;

    // word offsets
    localparam logic [ADDR_W-1:0] OFS_REV    = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_SYSCFG = 4'd1;
    localparam logic [ADDR_W-1:0] OFS_SYSSTA = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_ISTAT  = 4'd3;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_CTL    = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_FADDR  = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_TTB    = 4'd7;

    // sysconfig field positions
    localparam int CFG_AUTO_BIT  = 0;
    localparam int CFG_SRST_BIT  = 1;
    localparam int CFG_IDLE_LSB  = 3;

    typedef enum logic [1:0] {
        IDLE_FORCE = 2'd0,
        IDLE_NONE  = 2'd1,
        IDLE_SMART = 2'd2
    } idle_mode_e;

    typedef struct packed {
        idle_mode_e idle;
        logic       auto_idle;
    } syscfg_t;

    // msb first: emulator lookup, walker, datapath
    typedef struct packed {
        logic emu_lookup;
        logic walk_en;
        logic xlat_en;
    } ctl_t;

    localparam logic [DATA_W-1:0] TTB_MASK = {{(DATA_W-TTB_ALIGN){1'b1}}, {TTB_ALIGN{1'b0}}};

    function automatic logic idle_code_legal(input logic [1:0] code);
        return code != 2'd3;
    endfunction

endpackage

// File: rtl/mmu_srst_seq.sv
module mmu_srst_seq #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                remain <= LAST;
            end
        end else if (remain == '0) begin
            busy <= 1'b0;
        end else begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/mmu_irq_unit.sv
module mmu_irq_unit #(
    parameter int N  = 5,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          hold,
    input  logic [N-1:0]  evt,
    input  logic [AW-1:0] evt_addr,
    input  logic          stat_wr,
    input  logic          en_wr,
    input  logic [N-1:0]  wdata,
    output logic [N-1:0]  stat,
    output logic [N-1:0]  en,
    output logic [AW-1:0] fault_addr,
    output logic          irq
);
    logic [N-1:0] w1c_mask;
    logic         capture;

    assign w1c_mask = stat_wr ? wdata : '0;
    assign capture  = |(evt & en);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            stat       <= '0;
            en         <= '0;
            fault_addr <= '0;
        end else if (!hold) begin
            stat <= (stat & ~w1c_mask) | evt;
            if (en_wr)   en         <= wdata;
            if (capture) fault_addr <= evt_addr;
        end
    end

    assign irq = |(stat & en);
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
    import mmu_ctl_pkg::*;
#(
    parameter int SRST_CYCLES = SRST_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [DATA_W-1:0] evt_addr,
    output logic              irq,
    output logic [2:0]        ctl_en,
    output logic [1:0]        idle_mode,
    output logic              auto_idle,
    output logic [DATA_W-1:0] table_base
);
    syscfg_t             cfg_q;
    ctl_t                ctl_q;
    logic [DATA_W-1:0]   ttb_q;
    logic [NUM_EVT-1:0]  irq_stat;
    logic [NUM_EVT-1:0]  irq_en;
    logic [DATA_W-1:0]   flt_addr;
    logic                srst_busy;
    logic                srst_start;
    logic                wr_ok;
    logic                unused_wbits;

    assign wr_ok      = reg_wr && !srst_busy;
    assign srst_start = wr_ok && (reg_addr == OFS_SYSCFG) && reg_wdata[CFG_SRST_BIT];
    assign unused_wbits = ^reg_wdata[TTB_ALIGN-1:NUM_EVT];

    mmu_srst_seq #(.CYCLES(SRST_CYCLES)) u_srst (
        .clk   (clk),
        .rst   (rst),
        .start (srst_start),
        .busy  (srst_busy)
    );

    mmu_irq_unit #(.N(NUM_EVT), .AW(DATA_W)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .clr        (srst_start),
        .hold       (srst_busy),
        .evt        (evt_in),
        .evt_addr   (evt_addr),
        .stat_wr    (wr_ok && reg_addr == OFS_ISTAT),
        .en_wr      (wr_ok && reg_addr == OFS_IEN),
        .wdata      (reg_wdata[NUM_EVT-1:0]),
        .stat       (irq_stat),
        .en         (irq_en),
        .fault_addr (flt_addr),
        .irq        (irq)
    );

    always_ff @(posedge clk) begin
        if (rst || srst_start) begin
            cfg_q <= '{idle: IDLE_FORCE, auto_idle: 1'b0};
            ctl_q <= '0;
            ttb_q <= '0;
        end else if (wr_ok) begin
            case (reg_addr)
                OFS_SYSCFG: begin
                    cfg_q.auto_idle <= reg_wdata[CFG_AUTO_BIT];
                    if (idle_code_legal(reg_wdata[CFG_IDLE_LSB +: 2]))
                        cfg_q.idle <= idle_mode_e'(reg_wdata[CFG_IDLE_LSB +: 2]);
                end
                OFS_CTL: ctl_q <= ctl_t'(reg_wdata[3:1]);
                OFS_TTB: ttb_q <= reg_wdata & TTB_MASK;
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_REV:    reg_rdata[7:0] = REV_WORD;
            OFS_SYSCFG: begin
                reg_rdata[CFG_AUTO_BIT]       = cfg_q.auto_idle;
                reg_rdata[CFG_SRST_BIT]       = srst_busy;
                reg_rdata[CFG_IDLE_LSB +: 2]  = cfg_q.idle;
            end
            OFS_SYSSTA: reg_rdata[0]          = !srst_busy;
            OFS_ISTAT:  reg_rdata[NUM_EVT-1:0] = irq_stat;
            OFS_IEN:    reg_rdata[NUM_EVT-1:0] = irq_en;
            OFS_CTL:    reg_rdata[3:1]        = ctl_q;
            OFS_FADDR:  reg_rdata             = flt_addr;
            OFS_TTB:    reg_rdata             = ttb_q;
            default:    reg_rdata             = '0;
        endcase
    end

    assign ctl_en     = ctl_q;
    assign idle_mode  = cfg_q.idle;
    assign auto_idle  = cfg_q.auto_idle;
    assign table_base = ttb_q;
endmodule

// File: rtl/mmu_ctl_regs_chk.sv
module mmu_ctl_regs_chk
    import mmu_ctl_pkg::*;
#(
    parameter int SRST_CYCLES = SRST_LEN
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [NUM_EVT-1:0] evt_in,
    input logic [DATA_W-1:0]  evt_addr,
    input logic               irq,
    input logic [2:0]         ctl_en,
    input logic [DATA_W-1:0]  table_base,
    input logic [NUM_EVT-1:0] stat,
    input logic [NUM_EVT-1:0] en,
    input logic [DATA_W-1:0]  flt,
    input logic               busy
);
    localparam int BW = $clog2(SRST_CYCLES + 2);
    logic [BW-1:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst)       busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    // R3: soft-reset trigger clears outputs on the next cycle
    assert_srst_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !busy && reg_addr == OFS_SYSCFG && reg_wdata[CFG_SRST_BIT])
        |=> (busy && ctl_en == 3'b000 && !irq && table_base == '0 && stat == '0));

    // R3: reset window is exactly SRST_CYCLES long
    assert_srst_len_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == BW'(SRST_CYCLES)));

    // R5: events set their status bits
    assert_evt_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && !reg_wr && evt_in != '0) |=> ((stat & $past(evt_in)) == $past(evt_in)));

    // R7: event beats a same-cycle clear
    assert_evt_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && reg_wr && reg_addr == OFS_ISTAT && evt_in != '0)
        |=> ((stat & $past(evt_in)) == $past(evt_in)));

    // R6: without write or event the status is held
    assert_stat_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && evt_in == '0) |=> $stable(stat));

    // R8: the interrupt only rises after an event or a register write
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(evt_in) != '0 || $past(reg_wr)));

    // R10: base register drops the low alignment bits
    assert_ttb_align_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !busy && reg_addr == OFS_TTB)
        |=> (table_base == ($past(reg_wdata) & TTB_MASK)));

    // R11: an enabled event loads the fault address
    assert_fault_cap_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !reg_wr && (evt_in & en) != '0) |=> (flt == $past(evt_addr)));
endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk #(.SRST_CYCLES(SRST_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .evt_in     (evt_in),
    .evt_addr   (evt_addr),
    .irq        (irq),
    .ctl_en     (ctl_en),
    .table_base (table_base),
    .stat       (irq_stat),
    .en         (irq_en),
    .flt        (flt_addr),
    .busy       (srst_busy)
);

// File: tb/sim_mmu_ctl_regs.sv
`timescale 1ns/1ps
module sim_mmu_ctl_regs;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  evt_in = '0;
    logic [31:0] evt_addr = '0;
    logic        irq;
    logic [2:0]  ctl_en;
    logic [1:0]  idle_mode;
    logic        auto_idle;
    logic [31:0] table_base;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    mmu_ctl_regs u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
        .evt_addr(evt_addr), .irq(irq), .ctl_en(ctl_en),
        .idle_mode(idle_mode), .auto_idle(auto_idle), .table_base(table_base)
    );

    typedef struct packed {
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [31:0] expect_rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 32'h0000_0010, 32'h0000_0010, 4'd4},  // R4 smart-idle
        '{4'd1, 32'h0000_0008, 32'h0000_0008, 4'd4},  // R4 no-idle
        '{4'd1, 32'h0000_0019, 32'h0000_0009, 4'd4},  // R4 code 3 keeps field
        '{4'd5, 32'h0000_000F, 32'h0000_000E, 4'd9},  // R9
        '{4'd5, 32'h0000_0004, 32'h0000_0004, 4'd9},  // R9
        '{4'd7, 32'h1234_5678, 32'h1234_4000, 4'd10}, // R10
        '{4'd7, 32'hFFFF_FFFF, 32'hFFFF_C000, 4'd10}, // R10
        '{4'd4, 32'h0000_00FF, 32'h0000_001F, 4'd8},  // R8
        '{4'd4, 32'h0000_0000, 32'h0000_0000, 4'd8},  // R8
        '{4'd0, 32'h0000_0000, 32'h0000_0011, 4'd1},  // R1 read-only
        '{4'd9, 32'h0000_00AB, 32'h0000_0000, 4'd12}, // R12 unmapped
        '{4'd6, 32'h0000_0055, 32'h0000_0000, 4'd12}, // R12 fault addr read-only
        '{4'd1, 32'h0000_0011, 32'h0000_0011, 4'd4}   // R4 smart + auto
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [4:0] e, input logic [31:0] va);
        evt_in = e; evt_addr = va;
        @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R2 reset state
        rd(4'd0, v); check("R1", v, 32'h11);
        rd(4'd2, v); check("R2", v, 32'h1);
        for (int a = 1; a <= 7; a++) begin
            if (a != 2) begin
                rd(4'(a), v); check("R2", v, 32'h0);
            end
        end
        check("R2 irq", {31'b0, irq}, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].addr, VECS[i].wdata);
            rd(VECS[i].addr, v);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), v, VECS[i].expect_rd);
        end
        check("R9 ctl_en", {29'b0, ctl_en}, 32'h2);
        check("R4 idle_mode", {30'b0, idle_mode}, 32'h2);
        check("R4 auto_idle", {31'b0, auto_idle}, 32'h1);
        check("R10 table_base", table_base, 32'hFFFF_C000);

        // R5: events latch with enables off, no irq, no fault capture
        pulse(5'b10101, 32'h1111_0000);
        rd(4'd3, v); check("R5", v, 32'h15);
        check("R8 masked", {31'b0, irq}, 32'h0);
        rd(4'd6, v); check("R11 disabled", v, 32'h0);

        // R8: enable one latched bit
        wr(4'd4, 32'h04);
        check("R8 on", {31'b0, irq}, 32'h1);
        wr(4'd4, 32'h02);
        check("R8 off", {31'b0, irq}, 32'h0);

        // R6: write-one-to-clear
        wr(4'd3, 32'h01);
        rd(4'd3, v); check("R6 clear", v, 32'h14);
        wr(4'd3, 32'h00);
        rd(4'd3, v); check("R6 keep", v, 32'h14);

        // R7: same-cycle event and clear on bit 4
        evt_in = 5'b10000;
        wr(4'd3, 32'h10);
        evt_in = '0;
        rd(4'd3, v); check("R7", v, 32'h14);

        // R11: enabled event captures, disabled one does not
        pulse(5'b00001, 32'hAAAA_0000);
        rd(4'd6, v); check("R11 no capture", v, 32'h0);
        pulse(5'b00010, 32'hDEAD_1000);
        rd(4'd6, v); check("R11 capture", v, 32'hDEAD_1000);
        check("R8 fault irq", {31'b0, irq}, 32'h1);

        // R3: soft reset
        wr(4'd5, 32'h0E);
        wr(4'd1, 32'h02);
        rd(4'd2, v); check("R3 done low", v, 32'h0);
        rd(4'd1, v); check("R3 busy bit", v, 32'h2);
        check("R3 ctl cleared", {29'b0, ctl_en}, 32'h0);
        check("R3 irq cleared", {31'b0, irq}, 32'h0);
        wr(4'd5, 32'h0E);
        pulse(5'b11111, 32'h0BAD_0000);
        repeat (13) @(negedge clk);
        rd(4'd2, v); check("R3 last busy cycle", v, 32'h0);
        @(negedge clk);
        rd(4'd2, v); check("R3 done", v, 32'h1);
        rd(4'd1, v); check("R3 cfg", v, 32'h0);
        rd(4'd5, v); check("R3 write ignored", v, 32'h0);
        rd(4'd3, v); check("R3 event ignored", v, 32'h0);
        rd(4'd6, v); check("R3 fault cleared", v, 32'h0);
        rd(4'd7, v); check("R3 ttb cleared", v, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule